// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects level-sensitive interrupt requests from devices and turns them into two CPU interrupt lines. Requests arrive in three byte-wide groups: two local groups (group A and group B) and one shared mapped group. Every clock, the block samples each group into a status byte. Each local group has its own enable mask. The mapped group passes through two independent enable masks. The result of each mapped mask is folded into one fixed bit of a different local group. This forms a two-level cascade, so one mapped device can be steered to either CPU line or to both.

Software reaches the block through a synchronous byte register port with a 3-bit address, a write enable, write data and registered read data. It scans the status bytes to find which source is pending. It updates the masks by read-modify-write, because a mask reads back exactly what was stored. Logical interrupt numbers run 0-7 for group A bits, 8-15 for group B bits, 16-23 for mapped-mask-0 bits and 24-31 for mapped-mask-1 bits.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four mask registers and drives `cpu_irq0` and `cpu_irq1` low. After reset, every mask address reads 0x00, and both outputs stay low even with every request input high.
- R2: The mask registers are at these addresses: group A mask at 1, group B mask at 3, mapped mask 0 at 5, mapped mask 1 at 6. A write to one of them stores the write data. The value reads back unchanged.
- R3: Group A status is at address 0 and group B status is at address 2. Each reads the request levels sampled on the clock edge after they were applied. The cascade bit of the group is the exception (R8, R9).
- R4: The status addresses 0, 2 and 4 are read-only. A write to any of them changes no status byte and no mask.
- R5: `cpu_irq0` is a register. It goes high on the clock edge after group A status AND group A mask becomes non-zero. A request applied before edge k therefore raises `cpu_irq0` after edge k+1, and it is still low after edge k. The line falls the same way.
- R6: `cpu_irq1` follows the same rule for group B status AND group B mask.
- R7: The sampled mapped-group request byte reads at address 4.
- R8: Group A status bit 7 equals the OR of (mapped status AND mapped mask 0). The group A request input bit 7 is ignored.
- R9: Group B status bit 3 equals the OR of (mapped status AND mapped mask 1). The group B request input bit 3 is ignored.
- R10: A mapped request reaches a CPU line only when its bit is set in the mapped mask and the receiving cascade bit is also set in the local mask. With the local cascade bit cleared, the status shows the cascade bit set while the CPU line stays low.
- R11: Address 7 is unmapped and reads 0x00.
- R12: Read data is registered. `reg_rdata` shows the register selected by the address presented before the previous clock edge, so back-to-back reads of different addresses return their values on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_a_req | input | 8 | Group A request levels (bit 7 unused) |
| grp_b_req | input | 8 | Group B request levels (bit 3 unused) |
| map_req | input | 8 | Mapped-group request levels |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_irq0 | output | 1 | CPU interrupt line fed by group A |
| cpu_irq1 | output | 1 | CPU interrupt line fed by group B |

## Verification
The hardest case to reach is one where the cascade and the local masks disagree. A mapped request is enabled in a mapped mask while the receiving local cascade bit is masked, or the raw input bit at the cascade position is driven high with no mapped source behind it. The stimulus reprograms the masks between phases. It drives the cascade-position inputs high on purpose. It then reads both the status byte and the CPU line, so a leak through either path shows at the ports. Edge-exact latency checks on the CPU lines and back-to-back reads separate the registered paths from combinational ones.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int GRP_W  = 8;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = $clog2(GRP_W);
  localparam int N_MASK = 4;

  localparam logic [ADDR_W-1:0] A_GA_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_GA_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_GB_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GB_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MP_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MP_MASK0 = 3'd5;
  localparam logic [ADDR_W-1:0] A_MP_MASK1 = 3'd6;

  // Mask bank slot order
  localparam int M_GA  = 0;
  localparam int M_GB  = 1;
  localparam int M_MP0 = 2;
  localparam int M_MP1 = 3;

  function automatic logic any_enabled(input logic [GRP_W-1:0] stat,
                                       input logic [GRP_W-1:0] mask);
    return |(stat & mask);
  endfunction

  function automatic logic [GRP_W-1:0] inject_bit(input logic [GRP_W-1:0] raw,
                                                  input logic [IDX_W-1:0] pos,
                                                  input logic val);
    logic [GRP_W-1:0] r;
    r = raw;
    r[pos] = val;
    return r;
  endfunction
endpackage

// File: rtl/irq_sample_regs.sv
module irq_sample_regs
  import irq_cascade_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] req_i,
  output logic [GRP_W-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= req_i;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_cascade_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [GRP_W-1:0]             wdata_i,
  output logic [N_MASK-1:0][GRP_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] SLOT_ADDR [N_MASK] =
    '{A_GA_MASK, A_GB_MASK, A_MP_MASK0, A_MP_MASK1};

  for (genvar m = 0; m < N_MASK; m++) begin : g_mask
    logic hit;
    assign hit = we_i && (addr_i == SLOT_ADDR[m]);
    always_ff @(posedge clk) begin
      if (rst)      mask_o[m] <= '0;
      else if (hit) mask_o[m] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_cascade_merge.sv
module irq_cascade_merge
  import irq_cascade_pkg::*;
#(
  parameter int CASC0_BIT = 7,
  parameter int CASC1_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] ga_raw_i,
  input  logic [GRP_W-1:0] gb_raw_i,
  input  logic [GRP_W-1:0] mp_stat_i,
  input  logic [GRP_W-1:0] ga_mask_i,
  input  logic [GRP_W-1:0] gb_mask_i,
  input  logic [GRP_W-1:0] mp_mask0_i,
  input  logic [GRP_W-1:0] mp_mask1_i,
  output logic [GRP_W-1:0] ga_stat_o,
  output logic [GRP_W-1:0] gb_stat_o,
  output logic             casc0_o,
  output logic             casc1_o,
  output logic             pend0_o,
  output logic             pend1_o,
  output logic             irq0_o,
  output logic             irq1_o
);
  localparam logic [IDX_W-1:0] POS0 = IDX_W'(CASC0_BIT);
  localparam logic [IDX_W-1:0] POS1 = IDX_W'(CASC1_BIT);

  assign casc0_o   = any_enabled(mp_stat_i, mp_mask0_i);
  assign casc1_o   = any_enabled(mp_stat_i, mp_mask1_i);
  assign ga_stat_o = inject_bit(ga_raw_i, POS0, casc0_o);
  assign gb_stat_o = inject_bit(gb_raw_i, POS1, casc1_o);
  assign pend0_o   = any_enabled(ga_stat_o, ga_mask_i);
  assign pend1_o   = any_enabled(gb_stat_o, gb_mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
    end else begin
      irq0_o <= pend0_o;
      irq1_o <= pend1_o;
    end
  end
endmodule

// File: rtl/irq_reg_readmux.sv
module irq_reg_readmux
  import irq_cascade_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GRP_W-1:0]  ga_stat_i,
  input  logic [GRP_W-1:0]  ga_mask_i,
  input  logic [GRP_W-1:0]  gb_stat_i,
  input  logic [GRP_W-1:0]  gb_mask_i,
  input  logic [GRP_W-1:0]  mp_stat_i,
  input  logic [GRP_W-1:0]  mp_mask0_i,
  input  logic [GRP_W-1:0]  mp_mask1_i,
  output logic [GRP_W-1:0]  rdata_o
);
  logic [GRP_W-1:0] rd_nxt;

  always_comb begin
    case (addr_i)
      A_GA_STAT:  rd_nxt = ga_stat_i;
      A_GA_MASK:  rd_nxt = ga_mask_i;
      A_GB_STAT:  rd_nxt = gb_stat_i;
      A_GB_MASK:  rd_nxt = gb_mask_i;
      A_MP_STAT:  rd_nxt = mp_stat_i;
      A_MP_MASK0: rd_nxt = mp_mask0_i;
      A_MP_MASK1: rd_nxt = mp_mask1_i;
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int CASC0_BIT = 7,
  parameter int CASC1_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  grp_a_req,
  input  logic [GRP_W-1:0]  grp_b_req,
  input  logic [GRP_W-1:0]  map_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [GRP_W-1:0]  reg_wdata,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic              cpu_irq0,
  output logic              cpu_irq1
);
  localparam int N_GRP = 3;

  logic [N_GRP-1:0][GRP_W-1:0]  req_all;
  logic [N_GRP-1:0][GRP_W-1:0]  raw_stat;
  logic [N_MASK-1:0][GRP_W-1:0] mask_w;

  // Named internal events, observed by the bound checker
  logic [GRP_W-1:0] ga_status_w;
  logic [GRP_W-1:0] gb_status_w;
  logic [GRP_W-1:0] mp_status_w;
  logic             casc0_w;
  logic             casc1_w;
  logic             pend0_w;
  logic             pend1_w;

  assign req_all[0] = grp_a_req;
  assign req_all[1] = grp_b_req;
  assign req_all[2] = map_req;

  for (genvar g = 0; g < N_GRP; g++) begin : g_sample
    irq_sample_regs u_smp (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_all[g]),
      .stat_o (raw_stat[g])
    );
  end

  assign mp_status_w = raw_stat[2];

  irq_mask_bank u_masks (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .mask_o  (mask_w)
  );

  irq_cascade_merge #(
    .CASC0_BIT (CASC0_BIT),
    .CASC1_BIT (CASC1_BIT)
  ) u_merge (
    .clk        (clk),
    .rst        (rst),
    .ga_raw_i   (raw_stat[0]),
    .gb_raw_i   (raw_stat[1]),
    .mp_stat_i  (mp_status_w),
    .ga_mask_i  (mask_w[M_GA]),
    .gb_mask_i  (mask_w[M_GB]),
    .mp_mask0_i (mask_w[M_MP0]),
    .mp_mask1_i (mask_w[M_MP1]),
    .ga_stat_o  (ga_status_w),
    .gb_stat_o  (gb_status_w),
    .casc0_o    (casc0_w),
    .casc1_o    (casc1_w),
    .pend0_o    (pend0_w),
    .pend1_o    (pend1_w),
    .irq0_o     (cpu_irq0),
    .irq1_o     (cpu_irq1)
  );

  irq_reg_readmux u_rd (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (reg_addr),
    .ga_stat_i  (ga_status_w),
    .ga_mask_i  (mask_w[M_GA]),
    .gb_stat_i  (gb_status_w),
    .gb_mask_i  (mask_w[M_GB]),
    .mp_stat_i  (mp_status_w),
    .mp_mask0_i (mask_w[M_MP0]),
    .mp_mask1_i (mask_w[M_MP1]),
    .rdata_o    (reg_rdata)
  );
endmodule

// File: rtl/irq_cascade_checker.sv
module irq_cascade_checker
  import irq_cascade_pkg::*;
#(
  parameter int CASC0_BIT = 7,
  parameter int CASC1_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [GRP_W-1:0]  reg_rdata,
  input logic              cpu_irq0,
  input logic              cpu_irq1,
  input logic [GRP_W-1:0]  ga_stat,
  input logic [GRP_W-1:0]  gb_stat,
  input logic [GRP_W-1:0]  mp_stat,
  input logic [GRP_W-1:0]  ga_mask,
  input logic [GRP_W-1:0]  gb_mask,
  input logic [GRP_W-1:0]  mp_mask0,
  input logic [GRP_W-1:0]  mp_mask1,
  input logic              pend0,
  input logic              pend1
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1: reset leaves outputs low and masks cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!past_ok)
    rst |=> (!cpu_irq0 && !cpu_irq1 && ga_mask == '0 && gb_mask == '0
             && mp_mask0 == '0 && mp_mask1 == '0));

  // R2: a mask not addressed by a write holds its value
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !(reg_we && reg_addr == A_GA_MASK) |=> $stable(ga_mask));

  // R5: CPU line 0 follows group A pending one edge later
  p_irq0_latency_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    pend0 |=> cpu_irq0);

  // R6: CPU line 1 follows group B pending one edge later
  p_irq1_latency_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !pend1 |=> !cpu_irq1);

  // R8: group A cascade bit carries the mapped-mask-0 result
  p_cascade_a_r8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ga_stat[CASC0_BIT] == (|(mp_stat & mp_mask0)));

  // R9: group B cascade bit carries the mapped-mask-1 result
  p_cascade_b_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    gb_stat[CASC1_BIT] == (|(mp_stat & mp_mask1)));

  // R11: unmapped address reads zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (reg_addr == 3'd7) |=> (reg_rdata == '0));

  // R12: mask readback is registered
  p_read_reg_r12: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (reg_addr == A_GB_MASK && !reg_we) |=> (reg_rdata == $past(gb_mask)));
endmodule

bind irq_cascade_ctrl irq_cascade_checker #(
  .CASC0_BIT (CASC0_BIT),
  .CASC1_BIT (CASC1_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .cpu_irq0  (cpu_irq0),
  .cpu_irq1  (cpu_irq1),
  .ga_stat   (ga_status_w),
  .gb_stat   (gb_status_w),
  .mp_stat   (mp_status_w),
  .ga_mask   (mask_w[0]),
  .gb_mask   (mask_w[1]),
  .mp_mask0  (mask_w[2]),
  .mp_mask1  (mask_w[3]),
  .pend0     (pend0_w),
  .pend1     (pend1_w)
);

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] ga_req, gb_req, mp_req;
  logic [2:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq0, irq1;

  always #4 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk (clk), .rst (rst),
    .grp_a_req (ga_req), .grp_b_req (gb_req), .map_req (mp_req),
    .reg_addr (addr), .reg_we (we), .reg_wdata (wdata),
    .reg_rdata (rdata), .cpu_irq0 (irq0), .cpu_irq1 (irq1)
  );

  typedef struct {
    int         due;
    int         kind;   // 0 read data, 1 irq0, 2 irq1
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  // Bench-side model of the programmed masks
  logic [7:0] mk_a, mk_b, mk_m0, mk_m1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_a_stat();
    logic [7:0] s;
    s = ga_req;
    s[7] = |(mp_req & mk_m0);   // R8
    return s;
  endfunction

  function automatic logic [7:0] exp_b_stat();
    logic [7:0] s;
    s = gb_req;
    s[3] = |(mp_req & mk_m1);   // R9
    return s;
  endfunction

  // Monitor: compares every item due in the current cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [7:0] act;
        act = (sb[i].kind == 0) ? rdata :
              (sb[i].kind == 1) ? {7'd0, irq0} : {7'd0, irq1};
        n_run++;
        if (act !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", sb[i].tag, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(int due, int kind, logic [7:0] exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    addr = a; we = 1'b0;
    push(cyc + 1, 0, exp, tag);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; we = 1'b1; wdata = d;
    case (a)
      3'd1: mk_a  = d;
      3'd3: mk_b  = d;
      3'd5: mk_m0 = d;
      3'd6: mk_m1 = d;
      default: ;
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq(string tag);
    push(cyc + 1, 1, {7'd0, |(exp_a_stat() & mk_a)}, {tag, " irq0"});
    push(cyc + 1, 2, {7'd0, |(exp_b_stat() & mk_b)}, {tag, " irq1"});
    @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    ga_req = 8'hFF; gb_req = 8'hFF; mp_req = 8'hFF;
    mk_a = 0; mk_b = 0; mk_m0 = 0; mk_m1 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: masks cleared, lines low with all requests high
    rd(3'd1, 8'h00, "R1 mask A");
    rd(3'd3, 8'h00, "R1 mask B");
    rd(3'd5, 8'h00, "R1 map mask 0");
    rd(3'd6, 8'h00, "R1 map mask 1");
    chk_irq("R1");

    // R2: mask readback
    ga_req = 0; gb_req = 0; mp_req = 0;
    wr(3'd1, 8'hA5); wr(3'd3, 8'h3C); wr(3'd5, 8'h81); wr(3'd6, 8'h42);
    rd(3'd1, 8'hA5, "R2 mask A");
    rd(3'd3, 8'h3C, "R2 mask B");
    rd(3'd5, 8'h81, "R2 map mask 0");
    rd(3'd6, 8'h42, "R2 map mask 1");

    // R3 / R8: status sampling, raw bit 7 of group A ignored
    ga_req = 8'hD5; gb_req = 8'h2A;
    settle();
    rd(3'd0, exp_a_stat(), "R3 R8 group A status");
    rd(3'd2, exp_b_stat(), "R3 group B status");
    chk_irq("R5 R6 pattern 1");

    // R5: exact latency of irq0 rise, and later fall
    ga_req = 8'h00; gb_req = 8'h00;
    settle();
    chk_irq("R5 quiet");
    ga_req = 8'h04;
    push(cyc + 1, 1, 8'h00, "R5 irq0 one edge after request");
    push(cyc + 2, 1, 8'h01, "R5 irq0 two edges after request");
    @(negedge clk); @(negedge clk);
    ga_req = 8'h5A;
    settle();
    chk_irq("R5 masked pattern");

    // R6: irq1 latency
    gb_req = 8'h20;
    push(cyc + 1, 2, 8'h00, "R6 irq1 one edge after request");
    push(cyc + 2, 2, 8'h01, "R6 irq1 two edges after request");
    @(negedge clk); @(negedge clk);
    gb_req = 8'h03;
    settle();
    chk_irq("R6 masked pattern");

    // R7 / R8: mapped status and cascade into group A
    mp_req = 8'h81;
    settle();
    rd(3'd4, 8'h81, "R7 mapped status");
    rd(3'd0, exp_a_stat(), "R8 cascade bit set");
    chk_irq("R8 cascade drives irq0");

    // R9: cascade into group B, raw bit 3 ignored
    mp_req = 8'h00; gb_req = 8'h08;
    settle();
    rd(3'd2, exp_b_stat(), "R9 raw bit 3 ignored");
    chk_irq("R9 raw bit 3 no irq");
    mp_req = 8'h40; gb_req = 8'h00;
    settle();
    rd(3'd2, exp_b_stat(), "R9 cascade bit set");
    chk_irq("R9 cascade drives irq1");

    // R10: mapped enabled but local cascade bit masked
    wr(3'd1, 8'h25);
    mp_req = 8'h01; ga_req = 8'h00;
    settle();
    rd(3'd0, exp_a_stat(), "R10 status shows cascade");
    chk_irq("R10 local cascade masked");

    // R4: writes to status addresses are ignored
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    rd(3'd0, exp_a_stat(), "R4 group A status unchanged");
    rd(3'd2, exp_b_stat(), "R4 group B status unchanged");
    rd(3'd4, mp_req, "R4 mapped status unchanged");
    rd(3'd1, mk_a, "R4 mask A unchanged");
    rd(3'd6, mk_m1, "R4 map mask 1 unchanged");

    // R11: unmapped address
    rd(3'd7, 8'h00, "R11 unmapped");

    // R12: back-to-back reads on consecutive cycles
    rd(3'd3, mk_b, "R12 back-to-back first");
    rd(3'd5, mk_m0, "R12 back-to-back second");
    rd(3'd7, 8'h00, "R12 back-to-back third");

    drain();
    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule